// File: doc/BRIEF.md
# Bridge Power-Up and Hot-Plug Sequencer

This block drives the power pins of an external display bridge and decides when traffic to that bridge may start. A power request turns the supply on, releases power-down, and sends two reset pulses separated by a gap. The sequencer then waits a settling time and polls a hot-plug-detect (HPD) input at a fixed interval until it sees HPD high or a timeout runs out. Only the first HPD success after each reset adds an extra hold-off before `link_ready` rises.

All delays count ticks from a prescaler that divides the clock by `TICK_DIV`, so one tick can be set to one millisecond. The prescaler restarts whenever the state changes. A span of N ticks therefore lasts exactly N*TICK_DIV cycles. While ready, the block counts idle ticks and suspends by itself when the idle limit is reached. A new request restarts that count. A suspend request stops any sequence at once. A failed HPD wait leaves a sticky error flag set.

Top module: `bridge_pwrseq`

## Requirements
- R1: Out of reset, supply_en=0, bridge_pd=1, bridge_rst=1, link_ready=0 and hpd_err=0.
- R2: A pwr_req while off gives, from the next cycle, supply_en=1 and bridge_pd=0. It then drives bridge_rst high for T_RST_A ticks, low for T_GAP ticks, high for T_RST_B ticks, and then low (one tick = TICK_DIV cycles).
- R3: After the second reset release, the block waits T_SETTLE ticks before the first HPD sample. link_ready stays low throughout.
- R4: HPD is sampled on the first cycle of polling and then every T_POLL ticks. The first high sample ends polling with success.
- R5: The first HPD success after a reset pulse adds T_HOLD ticks before link_ready rises. Later successes raise link_ready on the next cycle.
- R6: A pwr_req while ready drops link_ready, re-polls HPD and restarts the idle count.
- R7: After T_IDLE ticks of ready, the block suspends. It spends one cycle with bridge_pd=1, bridge_rst=1 and supply_en still 1, then turns the supply off.
- R8: The timeout is tmo_ticks, captured with the accepted request; the value 0 selects T_TMO_DEF. A low sample at an elapsed poll time at or beyond the timeout sets hpd_err and starts the suspend cycle.
- R9: hpd_err stays set until the next pwr_req, which clears it on the following cycle.
- R10: A susp_req while powered has priority over pwr_req and enters the suspend cycle on the next cycle, even in mid-sequence. While off, susp_req and pwr_req together leave the block off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_req | input | 1 | Power-up / HPD wait request, one-cycle pulse |
| susp_req | input | 1 | Suspend request, one-cycle pulse |
| hpd_in | input | 1 | Hot-plug-detect indication from the bridge |
| tmo_ticks | input | 16 | HPD wait timeout in ticks, 0 selects default |
| supply_en | output | 1 | Bridge supply enable |
| bridge_pd | output | 1 | Bridge power-down, high = powered down |
| bridge_rst | output | 1 | Bridge reset, high = in reset |
| link_ready | output | 1 | Bridge powered and HPD seen |
| hpd_err | output | 1 | Sticky HPD timeout flag |

## Verification
A wrong state or a prescaler that is out of phase shows up first on bridge_rst. Each reset edge must fall on an exact multiple of TICK_DIV cycles from the request, so a miscount moves an edge by at least one tick. A first-success flag that is lost or kept too long moves the rise of link_ready by exactly T_HOLD ticks. A wrong timeout comparison moves the rise of hpd_err by one poll interval. A broken suspend path shows up within one cycle, as the supply dropping while power-down and reset are still low.

// File: rtl/bps_pkg.sv
package bps_pkg;

  localparam int CNT_W = 16;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_RST_A,
    ST_GAP,
    ST_RST_B,
    ST_SETTLE,
    ST_POLL,
    ST_HOLD,
    ST_READY,
    ST_SUSP
  } seq_state_e;

  // true on the last tick of a span of n ticks
  function automatic logic span_done(input logic tick,
                                     input logic [CNT_W-1:0] elapsed,
                                     input logic [CNT_W-1:0] n);
    return tick && (elapsed == n - 1'b1);
  endfunction

  // HPD is looked at when elapsed time is a whole number of poll periods
  function automatic logic poll_point(input logic [CNT_W-1:0] elapsed,
                                      input logic [CNT_W-1:0] period);
    return (period == '0) || ((elapsed % period) == '0);
  endfunction

  function automatic logic [CNT_W-1:0] pick_timeout(input logic [CNT_W-1:0] req,
                                                    input logic [CNT_W-1:0] dflt);
    return (req == '0) ? dflt : req;
  endfunction

endpackage

// File: rtl/bps_ticker.sv
module bps_ticker
  import bps_pkg::*;
#(
  parameter int TICK_DIV = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic             phase_zero,
  output logic             tick,
  output logic [CNT_W-1:0] elapsed
);

  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PHASE_LAST = PW'(TICK_DIV - 1);
  localparam logic [CNT_W-1:0] ELAPSED_MAX = '1;

  logic [PW-1:0] phase_q;

  assign tick       = (phase_q == PHASE_LAST);
  assign phase_zero = (phase_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      elapsed <= '0;
    end else if (restart) begin
      phase_q <= '0;
      elapsed <= '0;
    end else if (tick) begin
      phase_q <= '0;
      if (elapsed != ELAPSED_MAX) elapsed <= elapsed + 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  // a state change must start a fresh span with zero elapsed ticks
  assert_restart_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (elapsed == '0) && phase_zero);

endmodule

// File: rtl/bps_hpd_judge.sv
module bps_hpd_judge
  import bps_pkg::*;
#(
  parameter int T_POLL = 20
) (
  input  logic             in_poll,
  input  logic             phase_zero,
  input  logic [CNT_W-1:0] elapsed,
  input  logic [CNT_W-1:0] limit,
  input  logic             hpd,
  output logic             hit,
  output logic             give_up
);

  logic sample;

  assign sample  = in_poll && phase_zero && poll_point(elapsed, CNT_W'(T_POLL));
  assign hit     = sample && hpd;
  assign give_up = sample && !hpd && (elapsed >= limit);

endmodule

// File: rtl/bridge_pwrseq.sv
module bridge_pwrseq
  import bps_pkg::*;
#(
  parameter int TICK_DIV  = 100000,
  parameter int T_RST_A   = 2,
  parameter int T_GAP     = 50,
  parameter int T_RST_B   = 50,
  parameter int T_SETTLE  = 200,
  parameter int T_POLL    = 20,
  parameter int T_HOLD    = 50,
  parameter int T_IDLE    = 2000,
  parameter int T_TMO_DEF = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_req,
  input  logic        susp_req,
  input  logic        hpd_in,
  input  logic [15:0] tmo_ticks,
  output logic        supply_en,
  output logic        bridge_pd,
  output logic        bridge_rst,
  output logic        link_ready,
  output logic        hpd_err
);

  localparam logic [CNT_W-1:0] N_RST_A  = CNT_W'(T_RST_A);
  localparam logic [CNT_W-1:0] N_GAP    = CNT_W'(T_GAP);
  localparam logic [CNT_W-1:0] N_RST_B  = CNT_W'(T_RST_B);
  localparam logic [CNT_W-1:0] N_SETTLE = CNT_W'(T_SETTLE);
  localparam logic [CNT_W-1:0] N_HOLD   = CNT_W'(T_HOLD);
  localparam logic [CNT_W-1:0] N_IDLE   = CNT_W'(T_IDLE);
  localparam logic [CNT_W-1:0] N_TMO    = CNT_W'(T_TMO_DEF);

  seq_state_e state_q, state_d;
  logic             first_q;
  logic [CNT_W-1:0] tmo_q;
  logic             restart, phase_zero, tick;
  logic [CNT_W-1:0] elapsed;
  logic             hpd_hit, hpd_give_up;
  logic             accept_req;

  // named events used by the assertions and the state logic
  assign restart    = (state_d != state_q);
  assign accept_req = pwr_req && !susp_req &&
                      ((state_q == ST_OFF) || (state_q == ST_READY));

  bps_ticker #(.TICK_DIV(TICK_DIV)) u_ticker (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .phase_zero (phase_zero),
    .tick       (tick),
    .elapsed    (elapsed)
  );

  bps_hpd_judge #(.T_POLL(T_POLL)) u_judge (
    .in_poll    (state_q == ST_POLL),
    .phase_zero (phase_zero),
    .elapsed    (elapsed),
    .limit      (tmo_q),
    .hpd        (hpd_in),
    .hit        (hpd_hit),
    .give_up    (hpd_give_up)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:  if (pwr_req && !susp_req) state_d = ST_RST_A;
      ST_SUSP: state_d = ST_OFF;
      default: begin
        if (susp_req) begin
          state_d = ST_SUSP;
        end else begin
          unique case (state_q)
            ST_RST_A:  if (span_done(tick, elapsed, N_RST_A))  state_d = ST_GAP;
            ST_GAP:    if (span_done(tick, elapsed, N_GAP))    state_d = ST_RST_B;
            ST_RST_B:  if (span_done(tick, elapsed, N_RST_B))  state_d = ST_SETTLE;
            ST_SETTLE: if (span_done(tick, elapsed, N_SETTLE)) state_d = ST_POLL;
            ST_POLL: begin
              if (hpd_hit)          state_d = first_q ? ST_HOLD : ST_READY;
              else if (hpd_give_up) state_d = ST_SUSP;
            end
            ST_HOLD:   if (span_done(tick, elapsed, N_HOLD)) state_d = ST_READY;
            ST_READY: begin
              if (pwr_req)                             state_d = ST_POLL;
              else if (span_done(tick, elapsed, N_IDLE)) state_d = ST_SUSP;
            end
            default: state_d = ST_OFF;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      first_q <= 1'b0;
      tmo_q   <= N_TMO;
      hpd_err <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_req) tmo_q <= pick_timeout(tmo_ticks, N_TMO);
      // every reset pulse re-arms the one-shot hold-off
      if (state_d == ST_RST_A && state_q != ST_RST_A) first_q <= 1'b1;
      else if (state_q == ST_HOLD && state_d == ST_READY) first_q <= 1'b0;
      if (state_q == ST_POLL && hpd_give_up && !hpd_hit) hpd_err <= 1'b1;
      else if (pwr_req) hpd_err <= 1'b0;
    end
  end

  assign supply_en  = (state_q != ST_OFF);
  assign bridge_pd  = (state_q == ST_OFF) || (state_q == ST_SUSP);
  assign bridge_rst = (state_q == ST_OFF) || (state_q == ST_SUSP) ||
                      (state_q == ST_RST_A) || (state_q == ST_RST_B);
  assign link_ready = (state_q == ST_READY);

  assert_unpowered_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_en |-> bridge_pd && bridge_rst);

  assert_ready_from_hpd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ready) |-> ($past(state_q) == ST_POLL) || ($past(state_q) == ST_HOLD));

  assert_supply_drop_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_en) |-> $past(bridge_pd && bridge_rst));

  assert_err_enters_suspend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hpd_err) |-> bridge_pd && bridge_rst && !link_ready);

  assert_ready_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    link_ready |-> !hpd_err && !bridge_pd && !bridge_rst);

  assert_suspend_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_req && supply_en && !bridge_pd) |=> bridge_pd && bridge_rst && supply_en);

endmodule

// File: tb/tb_bridge_pwrseq.sv
`timescale 1ns/1ps
module tb_bridge_pwrseq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_req = 1'b0;
  logic        susp_req = 1'b0;
  logic        hpd_in = 1'b0;
  logic [15:0] tmo_ticks = '0;
  logic        supply_en, bridge_pd, bridge_rst, link_ready, hpd_err;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // tick = 4 cycles; spans in ticks: 2,3,3,5 settle, poll 2, hold 3, idle 10, timeout 6
  bridge_pwrseq #(
    .TICK_DIV(4), .T_RST_A(2), .T_GAP(3), .T_RST_B(3), .T_SETTLE(5),
    .T_POLL(2), .T_HOLD(3), .T_IDLE(10), .T_TMO_DEF(6)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .susp_req(susp_req),
    .hpd_in(hpd_in), .tmo_ticks(tmo_ticks), .supply_en(supply_en),
    .bridge_pd(bridge_pd), .bridge_rst(bridge_rst), .link_ready(link_ready),
    .hpd_err(hpd_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // after return the caller stands in cycle 0 of the accepted request
  task automatic fire_req();
    pwr_req = 1'b1;
    step(1);
    pwr_req = 1'b0;
  endtask

  task automatic fire_susp();
    susp_req = 1'b1;
    step(1);
    susp_req = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R1", "supply_en", supply_en, 0);
    chk("R1", "bridge_pd", bridge_pd, 1);
    chk("R1", "bridge_rst", bridge_rst, 1);
    chk("R1", "link_ready", link_ready, 0);
    chk("R1", "hpd_err", hpd_err, 0);
  endtask

  task automatic t_power_up_first();
    hpd_in = 1'b1; tmo_ticks = '0;
    fire_req();
    chk("R2", "c0 supply_en", supply_en, 1);
    chk("R2", "c0 bridge_pd", bridge_pd, 0);
    chk("R2", "c0 rst", bridge_rst, 1);
    step(7);  chk("R2", "c7 rst", bridge_rst, 1);
    step(1);  chk("R2", "c8 rst", bridge_rst, 0);
    step(11); chk("R2", "c19 rst", bridge_rst, 0);
    step(1);  chk("R2", "c20 rst", bridge_rst, 1);
    step(11); chk("R2", "c31 rst", bridge_rst, 1);
    step(1);  chk("R2", "c32 rst", bridge_rst, 0);
    step(20); chk("R3", "c52 ready", link_ready, 0);
    step(12); chk("R5", "c64 ready (hold)", link_ready, 0);
    step(1);  chk("R5", "c65 ready", link_ready, 1);
  endtask

  task automatic t_rerequest_and_idle();
    step(29); chk("R6", "r+29 ready", link_ready, 1);
    fire_req(); chk("R6", "re-poll ready", link_ready, 0);
    step(1);  chk("R5", "no hold on later success", link_ready, 1);
    step(10); chk("R6", "idle restarted", link_ready, 1);
    step(29); chk("R7", "r2+39 ready", link_ready, 1);
    step(1);
    chk("R7", "suspend ready", link_ready, 0);
    chk("R7", "suspend pd", bridge_pd, 1);
    chk("R7", "suspend rst", bridge_rst, 1);
    chk("R7", "suspend supply", supply_en, 1);
    step(1);  chk("R7", "supply off", supply_en, 0);
  endtask

  task automatic t_timeout_default();
    hpd_in = 1'b0; tmo_ticks = '0;
    fire_req();
    step(76); chk("R8", "c76 err", hpd_err, 0);
    chk("R8", "c76 ready", link_ready, 0);
    step(1);  chk("R8", "c77 err", hpd_err, 1);
    chk("R8", "c77 pd", bridge_pd, 1);
    chk("R8", "c77 supply", supply_en, 1);
    step(1);  chk("R8", "c78 supply", supply_en, 0);
  endtask

  task automatic t_sticky_and_short_timeout();
    step(5);  chk("R9", "err sticky", hpd_err, 1);
    tmo_ticks = 16'd3;
    fire_req(); chk("R9", "err cleared", hpd_err, 0);
    step(68); chk("R8", "c68 err tmo3", hpd_err, 0);
    step(1);  chk("R8", "c69 err tmo3", hpd_err, 1);
    step(2);
  endtask

  task automatic t_hpd_mid_poll();
    hpd_in = 1'b0; tmo_ticks = '0;
    fire_req();
    step(57); hpd_in = 1'b1;
    step(15); chk("R4", "c72 ready", link_ready, 0);
    step(1);  chk("R4", "c73 ready", link_ready, 1);
    chk("R9", "err after success", hpd_err, 0);
    fire_susp();
    chk("R10", "susp from ready pd", bridge_pd, 1);
    chk("R10", "susp from ready ready", link_ready, 0);
    step(1);  chk("R10", "susp supply off", supply_en, 0);
  endtask

  task automatic t_abort_and_off();
    fire_req();
    step(10); chk("R2", "c10 gap rst", bridge_rst, 0);
    susp_req = 1'b1; pwr_req = 1'b1;
    step(1);  susp_req = 1'b0; pwr_req = 1'b0;
    chk("R10", "abort pd", bridge_pd, 1);
    chk("R10", "abort rst", bridge_rst, 1);
    step(1);  chk("R10", "abort supply off", supply_en, 0);
    susp_req = 1'b1; pwr_req = 1'b1;
    step(3);  susp_req = 1'b0; pwr_req = 1'b0;
    chk("R10", "off stays off", supply_en, 0);
    step(1);  chk("R10", "off stays off later", supply_en, 0);
  endtask

  initial begin
    step(1);
    t_reset_state();
    step(2);
    rst_n = 1'b1;
    step(2);
    t_reset_state();
    t_power_up_first();
    t_rerequest_and_idle();
    t_timeout_default();
    t_sticky_and_short_timeout();
    t_hpd_mid_poll();
    t_abort_and_off();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog all-requirements actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule